// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block is a single-port synchronous SRAM with flow-through reads and a built-in four-beat burst address generator. On each rising clock edge it registers the address, three chip selects, two address strobes, the burst step control and the write controls. A processor-side strobe and a controller-side strobe can each open an access. A 2-bit wraparound counter then walks the low address bits in linear or interleaved order. Writes cover both byte lanes at once or only the lanes that are selected.

The data bus has two 9-bit lanes. It is split into a data-in vector, a data-out vector and one drive enable per lane, so that a pad ring or a test harness can build the shared bus from them. Read data reaches `dout` in the same cycle that follows the edge that registered the address. The output enable input is combinational and acts at once.

The pins are plain memory-style controls with no valid/ready handshake. The block never stalls: every edge is either an access edge, a burst continuation edge or an idle edge. A host that cannot take a beat holds the burst by keeping the step input high.

Top module: `burst_sram`

## Requirements
- R1: The part is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at the edge. A recognised strobe edge that fails this test deselects the part: nothing is written and `dout_oe` is 0 in the following cycle.
- R2: A recognised strobe on a selected part captures the whole address. If the part was already active, `dout` shows the word at that address in the cycle right after the edge, with no added pipeline cycle.
- R3: When both strobes are low and `sel1_n`=0, only the processor strobe counts, so the write controls at that edge are ignored. The processor strobe is ignored when `sel1_n`=1: with the controller strobe high, that edge continues the current burst.
- R4: With `order_ilv`=0, each edge with `step_n`=0 and no strobe advances the low two address bits as start plus beat count modulo 4 (start 2 gives 2,3,0,1,2).
- R5: With `order_ilv`=1 the low two bits are start XOR beat count (start 1 gives 1,0,3,2,1).
- R6: With `step_n`=1 and both strobes high, the burst address holds.
- R7: In an access opened by the processor strobe, the write controls at the opening edge are ignored. A write indicated at the next edge stores `din` at the captured address.
- R8: In an access opened by the controller strobe (processor strobe high), the write controls at that same edge apply, and a write stores `din` at the presented address.
- R9: `all_wr_n`=0 writes both lanes, whatever `lane_wr_en_n` and `lane_sel_n` hold.
- R10: Otherwise lane i (bits 9i+8:9i) is written only when `lane_wr_en_n`=0 and `lane_sel_n[i]`=0. With `lane_wr_en_n`=1 nothing is written.
- R11: `dout_oe` is 0 whenever `out_en_n`=1. The input acts without waiting for a clock edge.
- R12: In the cycle after an edge that wrote, `dout_oe` is 0 even when `out_en_n`=0.
- R13: In the first cycle after an access opens from the deselected state, `dout_oe` is 0. From the next cycle on it follows `out_en_n`.
- R14: A synchronous reset (`rst`=1) leaves the part deselected, with `dout_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| sel1_n | input | 1 | Select, active low; also gates the processor strobe |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enable for lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Combinational output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_oe | output | LANES | Per-lane drive enable for dout |

## Verification
The bench uses the defaults ADDR_W=6, LANE_W=9 and LANES=2, a 64-word array. At that size the bench keeps a shadow copy of every word it touches and checks each read beat against it. Two 9-bit lanes are enough to show that a lane write leaves the other lane unchanged. Bursts that start at low bits 1 and 2 wrap inside their group of four, and that wrap separates linear order from interleaved order.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  // Low two address bits for a beat, given start bits, beat count and order.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             step_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             out_en_n,
  output logic             load,
  output logic             adv,
  output logic             use_new_addr,
  output logic [LANES-1:0] wr_lanes,
  output logic             drive
);
  logic selected, p_go, c_go, strobe, cont;
  logic active_q, mask_q, wrote_q;
  logic [LANES-1:0] wr_dec;

  assign selected = !sel1_n && sel2 && !sel3_n;
  // processor strobe only counts while sel1_n is low; it outranks the other
  assign p_go   = !cpu_strobe_n && !sel1_n;
  assign c_go   = !ctl_strobe_n && !p_go;
  assign strobe = p_go || c_go;
  assign load   = strobe && selected;
  assign cont   = !strobe && active_q;
  assign adv    = cont && !step_n;

  assign wr_dec = {LANES{!all_wr_n}} | ({LANES{!lane_wr_en_n}} & ~lane_sel_n);
  assign use_new_addr = c_go && selected;
  assign wr_lanes = (use_new_addr || cont) ? wr_dec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mask_q   <= 1'b0;
      wrote_q  <= 1'b0;
    end else begin
      if (strobe) active_q <= selected;
      mask_q  <= load && !active_q;
      wrote_q <= |wr_lanes;
    end
  end

  assign drive = active_q && !mask_q && !wrote_q && !out_en_n;
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr
);
  import burst_sram_pkg::*;
  localparam int BASE_W = ADDR_W - 2;

  logic [BASE_W-1:0] base_q;
  logic [1:0]        start_q, beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      base_q  <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      beat_q  <= '0;
    end else if (adv) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign cur_addr = {base_q, beat_low(start_q, beat_q, ilv)};
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lanes[l]) mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end
    assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    step_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    order_ilv,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic [LANES-1:0]        dout_oe
);
  logic              load, adv, use_new_addr, drive;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] cur_addr, wr_addr;

  burst_sram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .step_n(step_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .load(load), .adv(adv),
    .use_new_addr(use_new_addr), .wr_lanes(wr_lanes), .drive(drive)
  );

  burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .ilv(order_ilv),
    .addr_in(addr), .cur_addr(cur_addr)
  );

  // a controller-opened write lands at the presented address; a burst
  // continuation write lands at the current beat address
  assign wr_addr = use_new_addr ? addr : cur_addr;

  burst_sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .wr_lanes(wr_lanes), .wr_addr(wr_addr), .wr_data(din),
    .rd_addr(cur_addr), .rd_data(dout)
  );

  assign dout_oe = {LANES{drive}};
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              step_n,
  input logic              all_wr_n,
  input logic              out_en_n,
  input logic [LANES-1:0]  dout_oe,
  input logic [ADDR_W-1:0] cur_addr
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dout_oe == '0); // R14

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ctl_strobe_n && cpu_strobe_n && (!sel2 || sel3_n)) |=> dout_oe == '0); // R1

  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!ctl_strobe_n && cpu_strobe_n && !sel1_n && sel2 && !sel3_n && !all_wr_n)
      |=> dout_oe == '0); // R12

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cpu_strobe_n && ctl_strobe_n && step_n) |=> $stable(cur_addr)); // R6

  AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> dout_oe == '0); // R11
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
  .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
  .all_wr_n(all_wr_n), .out_en_n(out_en_n), .dout_oe(dout_oe),
  .cur_addr(cur_addr)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 6, LW = 9, NL = 2, DW = LW * NL;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, step_n = 1'b1;
  logic all_wr_n = 1'b1, lane_wr_en_n = 1'b1, order_ilv = 1'b0, out_en_n = 1'b0;
  logic [NL-1:0] lane_sel_n = '1;
  logic [DW-1:0] din = '0, dout;
  logic [NL-1:0] dout_oe;

  logic [DW-1:0] shadow [1 << AW];
  int checks = 0, fails = 0;
  bit done = 0;

  burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) uut (
    .clk(clk), .rst(rst), .addr(addr), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .step_n(step_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .order_ilv(order_ilv), .out_en_n(out_en_n),
    .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
    all_wr_n = 1; lane_wr_en_n = 1; lane_sel_n = '1;
    sel1_n = 0; sel2 = 1; sel3_n = 0;
  endtask

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 32'h1357 + 32'h0ABC);
  endfunction

  task automatic ctl_write(int a, logic [DW-1:0] d);
    quiet(); ctl_strobe_n = 0; all_wr_n = 0; addr = AW'(a); din = d;
    tick();
    shadow[a] = d;
    quiet();
  endtask

  // open a read, let the first cycle pass, then compare the held word
  task automatic read_back(int a, string req);
    quiet(); ctl_strobe_n = 0; addr = AW'(a);
    tick();
    quiet();
    tick();
    check(req, 32'(dout_oe), 32'h3);
    check(req, 32'(dout), 32'(shadow[a]));
  endtask

  task automatic t_reset();
    repeat (3) tick();
    rst = 0;
    check("R14 idle after reset", 32'(dout_oe), 32'h0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 16; a++) ctl_write(a, pat(a));
    check("R12 hi-z after write", 32'(dout_oe), 32'h0);
    read_back(5, "R8 controller write");
  endtask

  task automatic t_flow_and_mask();
    read_back(3, "R2 setup");
    ctl_strobe_n = 0; addr = 9;
    tick();
    quiet();
    check("R2 flow-through oe", 32'(dout_oe), 32'h3);
    check("R2 flow-through data", 32'(dout), 32'(shadow[9]));
    ctl_strobe_n = 0; sel2 = 0; addr = 12; all_wr_n = 0; din = '1;
    tick();
    quiet();
    check("R1 deselect quiet", 32'(dout_oe), 32'h0);
    ctl_strobe_n = 0; addr = 9;
    tick();
    quiet();
    check("R13 first cycle masked", 32'(dout_oe), 32'h0);
    tick();
    check("R13 then driven", 32'(dout_oe), 32'h3);
    check("R6 held address", 32'(dout), 32'(shadow[9]));
    read_back(12, "R1 no write while deselected");
  endtask

  task automatic t_burst(logic ilv, int start, int step0, string req);
    read_back(0, req);
    order_ilv = ilv; ctl_strobe_n = 0; addr = AW'(start);
    tick();
    quiet();
    step_n = 0;
    for (int k = 0; k < 5; k++) begin
      int lo = ilv ? ((start & 3) ^ (k & 3)) : (((start & 3) + k) & 3);
      check(req, 32'(dout), 32'(shadow[(start & ~3) | lo]));
      tick();
    end
    quiet();
    order_ilv = 0;
    if (step0 != 0) check(req, 32'(dout_oe), 32'h3);
  endtask

  task automatic t_priority();
    read_back(1, "R3 setup");
    cpu_strobe_n = 0; ctl_strobe_n = 0; all_wr_n = 0; addr = 11; din = 18'h2AAAA;
    tick();
    quiet();
    check("R3 cpu strobe wins, no write", 32'(dout), 32'(shadow[11]));
    read_back(3, "R3 setup2");
    cpu_strobe_n = 0; sel1_n = 1; addr = 14;
    tick();
    quiet();
    check("R3 cpu strobe ignored oe", 32'(dout_oe), 32'h3);
    check("R3 cpu strobe ignored data", 32'(dout), 32'(shadow[3]));
  endtask

  task automatic t_cpu_write();
    read_back(0, "R7 setup");
    cpu_strobe_n = 0; all_wr_n = 0; addr = 10; din = 18'h11111;
    tick();
    quiet();
    check("R7 opening write ignored", 32'(dout), 32'(shadow[10]));
    all_wr_n = 0; din = 18'h2BEEF;
    tick();
    quiet();
    shadow[10] = 18'h2BEEF;
    read_back(10, "R7 late write");
  endtask

  task automatic t_lanes();
    quiet(); ctl_strobe_n = 0; lane_wr_en_n = 0; lane_sel_n = 2'b10;
    addr = 2; din = '1;
    tick();
    shadow[2][8:0] = 9'h1FF;
    read_back(2, "R10 lane 0 only");
    quiet(); ctl_strobe_n = 0; lane_sel_n = 2'b00; addr = 6; din = '0;
    tick();
    read_back(6, "R10 no enable no write");
    quiet(); ctl_strobe_n = 0; all_wr_n = 0; lane_wr_en_n = 1; lane_sel_n = 2'b11;
    addr = 4; din = 18'h12345;
    tick();
    shadow[4] = 18'h12345;
    read_back(4, "R9 all lanes");
  endtask

  task automatic t_oe();
    read_back(7, "R11 setup");
    out_en_n = 1;
    #1;
    check("R11 oe off", 32'(dout_oe), 32'h0);
    out_en_n = 0;
    #1;
    check("R11 oe on without clock", 32'(dout_oe), 32'h3);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) shadow[a] = '0;
    t_reset();
    t_fill();
    t_flow_and_mask();
    t_burst(1'b0, 6, 1, "R4 linear burst");
    t_burst(1'b1, 5, 1, "R5 interleaved burst");
    t_priority();
    t_cpu_write();
    t_lanes();
    t_oe();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule